// File: doc/BRIEF.md
# Mode-Checked Interrupt Status and Mask Registers

This block is the interrupt register bank of a controller that can run either as a bus host or as a bus device. Software talks to it through a simple request/response register port. It keeps a word of interrupt status flags and a matching enable word. It also keeps a secondary event word whose bits fold into one summary flag. From the status and enable words it drives a single interrupt line.

Each register address belongs to one of three classes: shared, host-side or device-side. The class is decoded from the top two address bits. When software touches a host-side register while the controller runs as a device, or a device-side register while it runs as a host, the access still gets a normal response. Its effect is thrown away, and a sticky mismatch flag is raised. Status and event flags are set by hardware pulses and cleared by software writing ones.

Word addresses, with ADDR_W = 8: status at 0x00, enable at 0x01 and event at 0x02 are shared. The host configuration word at 0x40 is host-side. The device configuration word at 0x80 is device-side. Status and enable bit layout: bit 0 is the mode, bit 1 is the mismatch flag, bit 2 is the event summary, and bits [SRC_LSB +: N_SRC] are the hardware sources.

Top module: `irqbank_top`

## Requirements
- R1: After reset, every flag, the enable word, both configuration words and `irq` are 0.
- R2: Status bit 0 reads the `host_mode` input (0 device, 1 host), and writes to it have no effect.
- R3: A pulse on `src_set[i]` sets status bit SRC_LSB+i. Writing 1 to that bit at address 0x00 clears it, and writing 0 leaves it. If a set and a clear land in the same cycle, the bit stays 1.
- R4: Event bits at 0x02 are set by `evt_set` and cleared by writing 1, with the set winning a same-cycle clash. Status bit 2 is 1 exactly while any event bit is 1, and writes to status bit 2 are ignored.
- R5: A valid access with address bits [7:6] = 01 in device mode, or = 10 in host mode, sets status bit 1. It still gets `rsp_valid`, and a read of this kind returns 0.
- R6: A mismatched write changes no register.
- R7: Only hardware sets status bit 1. Writing 1 to bit 1 of 0x00 clears it unless a new mismatch lands in the same cycle.
- R8: The enable word at 0x01 stores bits 1, 2 and the source bits. All other bits read 0, and 1 means enabled.
- R9: `irq` is the registered OR of the status bits ANDed with their enable bits. A disabled source still sets its status bit.
- R10: Reserved bits and unmapped addresses (anything other than 0x00-0x02, 0x40 and 0x80) read 0, and writes to them change nothing.
- R11: The configuration words at 0x40 and 0x80 are read-write CFG_W-bit registers when accessed in their own mode.
- R12: Every request is answered by `rsp_valid` one clock later, with read data for the state before the request's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | Current role: 1 host, 0 device |
| src_set | input | N_SRC | Hardware pulses setting source status bits |
| evt_set | input | N_EVT | Hardware pulses setting event bits |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Access completed (always OKAY) |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | 1 | Combined interrupt |

## Verification
A request driven before clock edge N is answered after edge N. `rsp_valid` and `rsp_rdata` are sampled just after that edge and compared against the reference state from before the edge. Flag and register updates also take effect at edge N. `irq` is one register further on, so it reflects the flags and enables from before edge N and is due one edge after they change. The bench samples it just after each edge and compares it with the reference value computed before updating its model. Hardware pulses and software clears in the same step are applied to the model with clears first and sets last, so same-cycle clashes are predicted as the set winning.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    typedef enum logic [1:0] {
        CLS_SHARED = 2'd0,
        CLS_HOST   = 2'd1,
        CLS_DEVICE = 2'd2,
        CLS_SPARE  = 2'd3
    } reg_class_e;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_EVENT  = 3'd3,
        SEL_HCFG   = 3'd4,
        SEL_DCFG   = 3'd5
    } rd_sel_e;

    typedef struct packed {
        logic    mismatch;
        logic    wr_status;
        logic    wr_enable;
        logic    wr_event;
        logic    wr_hcfg;
        logic    wr_dcfg;
        rd_sel_e rd_sel;
    } decode_t;

    localparam int BIT_MODE     = 0;
    localparam int BIT_MISMATCH = 1;
    localparam int BIT_SUMMARY  = 2;

    localparam int OFS_STATUS = 0;
    localparam int OFS_ENABLE = 1;
    localparam int OFS_EVENT  = 2;
    localparam int OFS_CFG    = 0;

    function automatic logic wrong_role(reg_class_e cls, logic host);
        return (cls == CLS_HOST && !host) || (cls == CLS_DEVICE && host);
    endfunction

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              host_mode,
    output decode_t           dec
);
    localparam int OFS_W = ADDR_W - 2;

    reg_class_e       cls;
    logic [OFS_W-1:0] ofs;
    logic             accept;
    rd_sel_e          sel;

    always_comb begin
        cls    = reg_class_e'(req_addr[ADDR_W-1 -: 2]);
        ofs    = req_addr[OFS_W-1:0];
        accept = req_valid && !wrong_role(cls, host_mode);
        sel    = SEL_NONE;
        unique case (cls)
            CLS_SHARED: begin
                if (ofs == OFS_W'(OFS_STATUS))      sel = SEL_STATUS;
                else if (ofs == OFS_W'(OFS_ENABLE)) sel = SEL_ENABLE;
                else if (ofs == OFS_W'(OFS_EVENT))  sel = SEL_EVENT;
            end
            CLS_HOST:   if (ofs == OFS_W'(OFS_CFG)) sel = SEL_HCFG;
            CLS_DEVICE: if (ofs == OFS_W'(OFS_CFG)) sel = SEL_DCFG;
            default:    sel = SEL_NONE;
        endcase

        dec           = '0;
        dec.mismatch  = req_valid && wrong_role(cls, host_mode);
        dec.rd_sel    = (accept && !req_write) ? sel : SEL_NONE;
        dec.wr_status = accept && req_write && (sel == SEL_STATUS);
        dec.wr_enable = accept && req_write && (sel == SEL_ENABLE);
        dec.wr_event  = accept && req_write && (sel == SEL_EVENT);
        dec.wr_hcfg   = accept && req_write && (sel == SEL_HCFG);
        dec.wr_dcfg   = accept && req_write && (sel == SEL_DCFG);
    end

endmodule

// File: rtl/irqbank_w1c.sv
module irqbank_w1c #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set_i[i])
                q[i] <= 1'b1;
            else if (clr_en && clr_data[i])
                q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/irqbank_combine.sv
module irqbank_combine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] status,
    input  logic [W-1:0] enable,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & enable);
    end

endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
    import irqbank_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int N_SRC   = 8,
    parameter int SRC_LSB = 8,
    parameter int N_EVT   = 8,
    parameter int CFG_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic [N_SRC-1:0]  src_set,
    input  logic [N_EVT-1:0]  evt_set,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] SRC_FIELD =
        {{(DATA_W-N_SRC){1'b0}}, {N_SRC{1'b1}}} << SRC_LSB;
    localparam logic [DATA_W-1:0] ENABLE_WR =
        SRC_FIELD | (DATA_W'(1) << BIT_MISMATCH) | (DATA_W'(1) << BIT_SUMMARY);

    decode_t           dec;
    logic [0:0]        mis_q;
    logic [N_SRC-1:0]  src_q;
    logic [N_EVT-1:0]  evt_q;
    logic [DATA_W-1:0] mask_q;
    logic [CFG_W-1:0]  hcfg_q;
    logic [CFG_W-1:0]  dcfg_q;
    logic [DATA_W-1:0] status_vec;
    logic [DATA_W-1:0] rd_word;

    irqbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .host_mode (host_mode),
        .dec       (dec)
    );

    irqbank_w1c #(.W(1)) u_mis (
        .clk      (clk),
        .rst      (rst),
        .set_i    (dec.mismatch),
        .clr_en   (dec.wr_status),
        .clr_data (req_wdata[BIT_MISMATCH]),
        .q        (mis_q)
    );

    irqbank_w1c #(.W(N_SRC)) u_src (
        .clk      (clk),
        .rst      (rst),
        .set_i    (src_set),
        .clr_en   (dec.wr_status),
        .clr_data (req_wdata[SRC_LSB +: N_SRC]),
        .q        (src_q)
    );

    irqbank_w1c #(.W(N_EVT)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt_set),
        .clr_en   (dec.wr_event),
        .clr_data (req_wdata[N_EVT-1:0]),
        .q        (evt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            hcfg_q <= '0;
            dcfg_q <= '0;
        end else begin
            if (dec.wr_enable) mask_q <= req_wdata & ENABLE_WR;
            if (dec.wr_hcfg)   hcfg_q <= req_wdata[CFG_W-1:0];
            if (dec.wr_dcfg)   dcfg_q <= req_wdata[CFG_W-1:0];
        end
    end

    always_comb begin
        status_vec                  = '0;
        status_vec[BIT_MODE]        = host_mode;
        status_vec[BIT_MISMATCH]    = mis_q[0];
        status_vec[BIT_SUMMARY]     = |evt_q;
        status_vec[SRC_LSB +: N_SRC] = src_q;
    end

    always_comb begin
        unique case (dec.rd_sel)
            SEL_STATUS: rd_word = status_vec;
            SEL_ENABLE: rd_word = mask_q;
            SEL_EVENT:  rd_word = {{(DATA_W-N_EVT){1'b0}}, evt_q};
            SEL_HCFG:   rd_word = {{(DATA_W-CFG_W){1'b0}}, hcfg_q};
            SEL_DCFG:   rd_word = {{(DATA_W-CFG_W){1'b0}}, dcfg_q};
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_word;
        end
    end

    irqbank_combine #(.W(DATA_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .status (status_vec),
        .enable (mask_q),
        .irq    (irq)
    );

endmodule

// File: rtl/irqbank_checker.sv
module irqbank_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CFG_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_mode,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq,
    input logic              mis_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [CFG_W-1:0]  hcfg_q,
    input logic [CFG_W-1:0]  dcfg_q
);
    logic [1:0] top_bits;
    logic       wrong;
    logic       clr_mis;

    always_comb begin
        top_bits = req_addr[ADDR_W-1 -: 2];
        wrong    = req_valid && ((top_bits == 2'b01 && !host_mode) ||
                                 (top_bits == 2'b10 &&  host_mode));
        clr_mis  = req_valid && req_write && (req_addr == '0) && req_wdata[1];
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && mask_q == '0 && !mis_q && !rsp_valid));

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r5_mismatch_sets: assert property (@(posedge clk) disable iff (rst)
        wrong |=> mis_q);

    a_r5_mismatch_read_zero: assert property (@(posedge clk) disable iff (rst)
        (wrong && !req_write) |=> (rsp_rdata == '0));

    a_r6_mismatch_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wrong && req_write) |=> ($stable(hcfg_q) && $stable(dcfg_q) && $stable(mask_q)));

    a_r7_mismatch_sticky: assert property (@(posedge clk) disable iff (rst)
        (mis_q && !clr_mis) |=> mis_q);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq);

endmodule

bind irqbank_top irqbank_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CFG_W  (CFG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_mode (host_mode),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .mis_q     (mis_q[0]),
    .mask_q    (mask_q),
    .hcfg_q    (hcfg_q),
    .dcfg_q    (dcfg_q)
);

// File: tb/irqbank_top_tb.sv
module irqbank_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT = 8'h00, A_EN = 8'h01, A_EVT = 8'h02,
                           A_HCFG = 8'h40, A_DCFG = 8'h80,
                           A_SPARE = 8'hC5, A_GAP = 8'h07;
    localparam logic [31:0] EN_WR = 32'h0000_FF06;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_mode = 1'b0;
    logic [7:0]  src_set = '0;
    logic [7:0]  evt_set = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    logic [7:0]  m_src = '0;
    logic [7:0]  m_evt = '0;
    logic        m_mis = 1'b0;
    logic [31:0] m_en = '0;
    logic [15:0] m_hcfg = '0;
    logic [15:0] m_dcfg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqbank_top u_dut (
        .clk(clk), .rst(rst), .host_mode(host_mode),
        .src_set(src_set), .evt_set(evt_set),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    function automatic logic [31:0] m_status();
        return {16'h0, m_src, 5'h0, |m_evt, m_mis, host_mode};
    endfunction

    function automatic logic is_wrong(logic [7:0] a);
        return (a[7:6] == 2'b01 && !host_mode) || (a[7:6] == 2'b10 && host_mode);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            A_STAT:  return m_status();
            A_EN:    return m_en;
            A_EVT:   return {24'h0, m_evt};
            A_HCFG:  return {16'h0, m_hcfg};
            A_DCFG:  return {16'h0, m_dcfg};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic [7:0] s,
                        input logic [7:0] e, input string req);
        logic        wrong;
        logic [31:0] exp_rd;
        logic        exp_irq;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        src_set = s; evt_set = e;
        wrong   = v && is_wrong(a);
        exp_rd  = (v && !w && !wrong) ? m_read(a) : 32'h0;
        exp_irq = |(m_status() & m_en);
        if (v && w && !wrong) begin
            case (a)
                A_STAT: begin
                    m_src = m_src & ~d[15:8];
                    if (d[1]) m_mis = 1'b0;
                end
                A_EN:   m_en   = d & EN_WR;
                A_EVT:  m_evt  = m_evt & ~d[7:0];
                A_HCFG: m_hcfg = d[15:0];
                A_DCFG: m_dcfg = d[15:0];
                default: ;
            endcase
        end
        m_src = m_src | s;
        m_evt = m_evt | e;
        if (wrong) m_mis = 1'b1;
        @(posedge clk);
        #1;
        check(rsp_valid == v, {req, " R12 rsp_valid"}, {31'h0, rsp_valid}, {31'h0, v});
        if (v && !w)
            check(rsp_rdata == exp_rd, {req, " read"}, rsp_rdata, exp_rd);
        check(irq == exp_irq, {req, " R9 irq"}, {31'h0, irq}, {31'h0, exp_irq});
        req_valid = 1'b0; src_set = '0; evt_set = '0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(1'b1, 1'b0, a, 32'h0, 8'h0, 8'h0, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        step(1'b1, 1'b1, a, d, 8'h0, 8'h0, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 8'h0, 32'h0, 8'h0, 8'h0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] addrs [8];
        int seed_sink;
        addrs = '{A_STAT, A_EN, A_EVT, A_HCFG, A_DCFG, A_SPARE, A_GAP, A_STAT};
        seed_sink = $urandom(32'd20240611);

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        #1;
        check(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
        rd(A_STAT, "R1 status");
        rd(A_EN,   "R1 enable");
        rd(A_EVT,  "R1 event");
        rd(A_DCFG, "R1 dcfg");

        // R2: mode bit, read only
        wr(A_STAT, 32'h1, "R2 write mode bit");
        rd(A_STAT, "R2 device reads 0");
        @(negedge clk); host_mode = 1'b1;
        rd(A_STAT, "R2 host reads 1");
        rd(A_HCFG, "R1 hcfg");

        // R3: source set / w1c / set-wins
        step(1'b0, 1'b0, 8'h0, 32'h0, 8'h81, 8'h0, "R3 pulse");
        rd(A_STAT, "R3 set visible");
        wr(A_STAT, 32'h0, "R3 write zero");
        rd(A_STAT, "R3 zero no effect");
        wr(A_STAT, 32'h0000_0100, "R3 clear bit");
        rd(A_STAT, "R3 cleared");
        step(1'b1, 1'b1, A_STAT, 32'h0000_8000, 8'h80, 8'h0, "R3 set wins");
        rd(A_STAT, "R3 set wins read");

        // R4: events and summary
        step(1'b0, 1'b0, 8'h0, 32'h0, 8'h0, 8'h24, "R4 event pulse");
        rd(A_STAT, "R4 summary set");
        wr(A_STAT, 32'h4, "R4 summary write ignored");
        rd(A_STAT, "R4 summary still set");
        wr(A_EVT, 32'h04, "R4 clear one");
        rd(A_STAT, "R4 summary with one left");
        step(1'b1, 1'b1, A_EVT, 32'h20, 8'h0, 8'h20, "R4 set wins");
        wr(A_EVT, 32'hFF, "R4 clear all");
        rd(A_STAT, "R4 summary clear");

        // R11: configuration words in own mode
        wr(A_HCFG, 32'hFFFF_A5C3, "R11 hcfg write");
        rd(A_HCFG, "R11 hcfg read");

        // R5 / R6: mismatches
        wr(A_DCFG, 32'h1234, "R6 device write in host mode");
        rd(A_STAT, "R5 flag set");
        rd(A_DCFG, "R5 mismatched read zero");
        @(negedge clk); host_mode = 1'b0;
        wr(A_HCFG, 32'h0, "R6 host write in device mode");
        rd(A_DCFG, "R6 dcfg unchanged");
        wr(A_DCFG, 32'h00BE, "R11 dcfg write");
        rd(A_DCFG, "R11 dcfg read");

        // R7: clearing mismatch, set wins
        wr(A_STAT, 32'h2, "R7 clear flag");
        rd(A_STAT, "R7 flag cleared");
        wr(A_STAT, 32'h0, "R7 zero keeps");
        rd(A_HCFG, "R7 new mismatch");
        wr(A_STAT, 32'h0, "R7 zero write");
        rd(A_STAT, "R7 flag sticky");
        wr(A_STAT, 32'h2, "R7 clear again");

        // R8 / R10: enable layout and reserved space
        wr(A_EN, 32'hFFFF_FFFF, "R8 enable all");
        rd(A_EN, "R8 enable readback");
        wr(A_SPARE, 32'hFFFF_FFFF, "R10 spare write");
        rd(A_SPARE, "R10 spare read");
        wr(A_GAP, 32'hFFFF_FFFF, "R10 gap write");
        rd(A_GAP, "R10 gap read");

        // R9: masked source still sets status
        wr(A_EN, 32'h0, "R9 disable all");
        step(1'b0, 1'b0, 8'h0, 32'h0, 8'h10, 8'h0, "R9 masked pulse");
        idle("R9 no irq");
        rd(A_STAT, "R9 status set while masked");
        wr(A_EN, 32'h0000_1000, "R9 enable source");
        idle("R9 irq rises");
        idle("R9 irq held");
        wr(A_STAT, 32'h0000_1000, "R9 clear source");
        idle("R9 irq falls");

        // randomised traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [7:0]  s;
            logic [7:0]  e;
            if (($urandom % 40) == 0) begin
                @(negedge clk); host_mode = ~host_mode;
            end
            a = addrs[$urandom % 8];
            d = $urandom;
            s = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
            e = (($urandom % 5) == 0) ? 8'($urandom) : 8'h0;
            step(($urandom % 4) != 0, $urandom % 2, a, d, s, e, "R3 R4 R5 R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule